// File: doc/BRIEF.md
# Transmit Buffer Cancellation Controller

This block keeps two per-buffer bit vectors for a message controller with `N_BUF` transmit buffers. The ready vector marks buffers that are waiting to be sent. The cancel vector marks buffers whose withdrawal the host has asked for. Host strobes set bits in either vector. The block then decides, one buffer at a time, when a cancellation can take effect. It must not disturb a transfer the transmit engine is carrying out, and it must not disturb a selection round the scheduler is running.

A cancellation completes in one of three ways:
- If nothing blocks it, it completes at the clock edge after it is accepted.
- If the buffer is the one the transmit engine currently holds, it waits for the end-of-transmission pulse.
- While the scheduler reports a round in progress, every pending cancellation is held.

On completion, the cancel bit and the ready bit of that buffer are cleared together. If interrupts are enabled, a sticky done flag and the interrupt line are raised. The host tracks progress by polling the cancel vector and can clear the done flag by writing one to it.

Top module: `txb_cancel_ctrl`

## Requirements
- R1: While `rst_ni` is low, `ready_o`, `cancel_o`, `done_o` and `irq_o` are all zero.
- R2: A cancel strobe bit is accepted only if the matching `ready_o` bit is already 1. Otherwise it is ignored, and both vectors are unchanged at the next edge.
- R3: One cancel strobe word may target several buffers. Each targeted bit is qualified and completed on its own.
- R4: A cancel strobe to a buffer whose cancel bit is already set changes neither vector.
- R5: An accepted cancel sets its `cancel_o` bit at the next edge. If the buffer is not blocked, both that cancel bit and its ready bit clear at the edge after that.
- R6: A buffer equal to `lock_idx_i` while `lock_valid_i` is high keeps its cancel and ready bits until an edge where `tx_end_i` is high. It then completes whatever the outcome of the transfer. Other buffers are not delayed.
- R7: While `sched_busy_i` is high, no cancellation completes. Pending ones complete at the first edge with `sched_busy_i` low.
- R8: A completion with `ien_cancel_i` or `ien_global_i` high sets `done_o` at that edge. `irq_o` equals `done_o` AND (`ien_cancel_i` OR `ien_global_i`). A completion with both enables low leaves `done_o` at 0.
- R9: `done_o` is sticky and clears at an edge where `done_clr_i` is high. A new completion in that same cycle wins.
- R10: If a ready strobe and a completion hit the same buffer in one cycle, the ready bit ends at 0.
- R11: A ready strobe bit sets the matching `ready_o` bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ready_set_i | input | N_BUF | Host strobe, one bit per buffer, sets ready bits |
| cancel_set_i | input | N_BUF | Host strobe, one bit per buffer, requests cancellation |
| lock_valid_i | input | 1 | Transmit engine holds a buffer |
| lock_idx_i | input | IDX_W | Index of the held buffer |
| tx_end_i | input | 1 | End-of-transmission pulse (success, lost arbitration or error) |
| sched_busy_i | input | 1 | Scheduler selection round in progress |
| ien_cancel_i | input | 1 | Dedicated cancel-done interrupt enable |
| ien_global_i | input | 1 | General interrupt enable |
| done_clr_i | input | 1 | Write-one-to-clear strobe for the done flag |
| ready_o | output | N_BUF | Ready vector |
| cancel_o | output | N_BUF | Cancel vector; a zero bit means no cancellation pending |
| done_o | output | 1 | Sticky cancel-done flag |
| irq_o | output | 1 | Interrupt line |

## Verification
Cancellation is tried under four conditions:
- an idle buffer,
- the buffer the engine holds,
- a busy scheduler,
- a buffer with no ready bit.

Comparing the idle case with the held case shows whether the lock is decoded per buffer rather than globally. Comparing the held case with the busy-scheduler case shows that one deferral releases on the transfer pulse and the other on the round ending. Mixed strobe words separate per-bit qualification from whole-word handling. Repeated strobes, and a ready strobe landing on the completion cycle, expose priority mistakes. Interrupt cases toggle each enable on its own and exercise the clear strobe.

// File: rtl/txb_cancel_pkg.sv
package txb_cancel_pkg;
  localparam int unsigned DEF_N_BUF = 32;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/txb_cancel_slice.sv
module txb_cancel_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_set_i,
  input  logic cancel_set_i,
  input  logic locked_i,
  input  logic tx_end_i,
  input  logic sched_busy_i,
  output logic ready_o,
  output logic cancel_o,
  output logic complete_o
);
  logic ready_q, cancel_q, blocked, accept;

  // engine lock holds until end pulse; scheduler round holds everything
  assign blocked    = sched_busy_i | (locked_i & ~tx_end_i);
  assign complete_o = cancel_q & ~blocked;
  assign accept     = cancel_set_i & ready_q & ~cancel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (complete_o) begin
        ready_q  <= 1'b0;
        cancel_q <= 1'b0;
      end else begin
        if (ready_set_i) ready_q <= 1'b1;
        if (accept)      cancel_q <= 1'b1;
      end
    end
  end

  assign ready_o  = ready_q;
  assign cancel_o = cancel_q;

  // R2 cancel only rises on a buffer that was ready
  a_r2_accept_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cancel_q) |-> $past(ready_q));
  a_r2_cancel_implies_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_q |-> ready_q);
  // R6 R7 deferred cancel stays pending
  a_r6_hold_while_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_q && (sched_busy_i || (locked_i && !tx_end_i))) |=> cancel_q);
  // R5 R10 completion clears both bits
  a_r5_complete_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_q && !sched_busy_i && (!locked_i || tx_end_i)) |=> (!cancel_q && !ready_q));
endmodule

// File: rtl/txb_cancel_irq.sv
module txb_cancel_irq #(
  parameter int unsigned N_BUF = txb_cancel_pkg::DEF_N_BUF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_BUF-1:0] complete_i,
  input  logic             ien_cancel_i,
  input  logic             ien_global_i,
  input  logic             done_clr_i,
  output logic             done_o,
  output logic             irq_o
);
  logic done_q, ien_any, any_done;

  assign ien_any  = ien_cancel_i | ien_global_i;
  assign any_done = |complete_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                done_q <= 1'b0;
    else if (any_done && ien_any) done_q <= 1'b1;  // set wins over clear
    else if (done_clr_i)        done_q <= 1'b0;
  end

  assign done_o = done_q;
  assign irq_o  = done_q & ien_any;

  a_r8_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_done && ien_any) |=> done_q);
  a_r9_clear_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_clr_i && !(any_done && ien_any)) |=> !done_q);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !done_clr_i) |=> done_q);
endmodule

// File: rtl/txb_cancel_ctrl.sv
module txb_cancel_ctrl #(
  parameter int unsigned N_BUF = txb_cancel_pkg::DEF_N_BUF,
  localparam int unsigned IDX_W = txb_cancel_pkg::idx_w(N_BUF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_BUF-1:0] ready_set_i,
  input  logic [N_BUF-1:0] cancel_set_i,
  input  logic             lock_valid_i,
  input  logic [IDX_W-1:0] lock_idx_i,
  input  logic             tx_end_i,
  input  logic             sched_busy_i,
  input  logic             ien_cancel_i,
  input  logic             ien_global_i,
  input  logic             done_clr_i,
  output logic [N_BUF-1:0] ready_o,
  output logic [N_BUF-1:0] cancel_o,
  output logic             done_o,
  output logic             irq_o
);
  logic [N_BUF-1:0] complete;

  for (genvar b = 0; b < N_BUF; b++) begin : g_buf
    logic locked;
    assign locked = lock_valid_i && (lock_idx_i == IDX_W'(b));

    txb_cancel_slice u_slice (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ready_set_i  (ready_set_i[b]),
      .cancel_set_i (cancel_set_i[b]),
      .locked_i     (locked),
      .tx_end_i     (tx_end_i),
      .sched_busy_i (sched_busy_i),
      .ready_o      (ready_o[b]),
      .cancel_o     (cancel_o[b]),
      .complete_o   (complete[b])
    );
  end

  txb_cancel_irq #(.N_BUF(N_BUF)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .complete_i   (complete),
    .ien_cancel_i (ien_cancel_i),
    .ien_global_i (ien_global_i),
    .done_clr_i   (done_clr_i),
    .done_o       (done_o),
    .irq_o        (irq_o)
  );

  // R7 nothing completes during a scheduling round
  a_r7_sched_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_busy_i |=> (cancel_o == $past(cancel_o)) || ($past(cancel_o) == '0) ||
                     ((cancel_o & ~$past(cancel_o)) != '0) || (cancel_o == $past(cancel_o)));
  a_r7_no_drop_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_busy_i |=> (($past(cancel_o) & ~cancel_o) == '0));
endmodule

// File: tb/txb_cancel_ctrl_tb_top.sv
module txb_cancel_ctrl_tb_top;
  localparam int unsigned N = 32;
  localparam int unsigned IW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] ready_set_i = '0, cancel_set_i = '0;
  logic lock_valid_i = 0, tx_end_i = 0, sched_busy_i = 0;
  logic [IW-1:0] lock_idx_i = '0;
  logic ien_cancel_i = 0, ien_global_i = 0, done_clr_i = 0;
  logic [N-1:0] ready_o, cancel_o;
  logic done_o, irq_o;
  int n_chk = 0, n_err = 0;

  always #10 clk_i = ~clk_i;

  txb_cancel_ctrl #(.N_BUF(N)) dut_i (.*);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk_i); #2; endtask

  task automatic do_reset();
    rst_ni = 0; #3;
    chk({ready_o, cancel_o}, '0, "R1 vectors in reset");
    chk({done_o, irq_o}, '0, "R1 flags in reset");
    tick(); rst_ni = 1; tick();
  endtask

  task automatic set_ready(input logic [N-1:0] m);
    ready_set_i = m; tick(); ready_set_i = '0;
  endtask

  task automatic t_immediate();
    set_ready(N'(1) << 5);
    chk(ready_o, N'(1) << 5, "R11 ready set");
    cancel_set_i = N'(1) << 5; tick(); cancel_set_i = '0;
    chk(cancel_o, N'(1) << 5, "R5 cancel set");
    tick();
    chk({ready_o, cancel_o}, '0, "R5 both cleared");
    chk(done_o, 0, "R8 no done when disabled");
  endtask

  task automatic t_not_ready();
    cancel_set_i = N'(1) << 10; tick(); cancel_set_i = '0;
    chk({ready_o, cancel_o}, '0, "R2 ignored");
  endtask

  task automatic t_multi();
    set_ready((N'(1) << 0) | (N'(1) << 1) | (N'(1) << 31));
    cancel_set_i = (N'(1) << 0) | (N'(1) << 1) | (N'(1) << 31) | (N'(1) << 6);
    tick(); cancel_set_i = '0;
    chk(cancel_o, (N'(1) << 0) | (N'(1) << 1) | (N'(1) << 31), "R3 per-bit accept");
    tick();
    chk({ready_o, cancel_o}, '0, "R3 all completed");
  endtask

  task automatic t_locked();
    set_ready((N'(1) << 3) | (N'(1) << 4));
    lock_valid_i = 1; lock_idx_i = 3;
    cancel_set_i = (N'(1) << 3) | (N'(1) << 4); tick(); cancel_set_i = '0;
    tick();
    chk(cancel_o, N'(1) << 3, "R6 other buffer not delayed");
    for (int i = 0; i < 4; i++) tick();
    chk({ready_o, cancel_o}, {N'(1) << 3, N'(1) << 3}, "R6 held while locked");
    tx_end_i = 1; tick(); tx_end_i = 0; lock_valid_i = 0;
    chk({ready_o, cancel_o}, '0, "R6 completes on tx end");
  endtask

  task automatic t_sched();
    ien_cancel_i = 1;
    set_ready((N'(1) << 7) | (N'(1) << 9));
    sched_busy_i = 1;
    cancel_set_i = (N'(1) << 7) | (N'(1) << 9); tick(); cancel_set_i = '0;
    tick(); tick();
    chk(cancel_o, (N'(1) << 7) | (N'(1) << 9), "R7 held while busy");
    chk(done_o, 0, "R7 no done while busy");
    cancel_set_i = N'(1) << 7; tick(); cancel_set_i = '0;
    chk({ready_o, cancel_o}, {(N'(1) << 7) | (N'(1) << 9), (N'(1) << 7) | (N'(1) << 9)},
        "R4 duplicate no effect");
    sched_busy_i = 0; tick();
    chk({ready_o, cancel_o}, '0, "R7 completes after round");
    chk({done_o, irq_o}, 2'b11, "R8 done and irq via dedicated enable");
    done_clr_i = 1; tick(); done_clr_i = 0;
    chk(done_o, 0, "R9 w1c clears");
    ien_cancel_i = 0;
  endtask

  task automatic t_global_irq();
    ien_global_i = 1;
    set_ready(N'(1) << 2);
    cancel_set_i = N'(1) << 2; tick(); cancel_set_i = '0;
    tick();
    chk({done_o, irq_o}, 2'b11, "R8 general enable");
    ien_global_i = 0; #1;
    chk({done_o, irq_o}, 2'b10, "R8 irq masked, done sticky");
    tick();
    chk(done_o, 1, "R9 sticky");
    done_clr_i = 1; tick(); done_clr_i = 0;
    chk(done_o, 0, "R9 cleared");
  endtask

  task automatic t_race();
    set_ready(N'(1) << 12);
    cancel_set_i = N'(1) << 12; tick(); cancel_set_i = '0;
    ready_set_i = N'(1) << 12; tick(); ready_set_i = '0;
    chk({ready_o, cancel_o}, '0, "R10 completion wins");
  endtask

  task automatic t_reset_mid();
    set_ready(N'(1) << 20);
    rst_ni = 0; #3;
    chk(ready_o, '0, "R1 async reset clears");
    tick(); rst_ni = 1; tick();
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_immediate();
        t_not_ready();
        t_multi();
        t_locked();
        t_sched();
        t_global_irq();
        t_race();
        t_reset_mid();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule